// File: doc/BRIEF.md
# Streaming Test Pattern Generator

This block is a stream master for link and loopback testing. It sends packets of a fixed byte length, one after another, for as long as it is enabled. A fixed number of idle cycles separates each packet from the next. The payload is not structured data. It is a single data word, built from a 32-bit seed, that rotates left by one bit each time a beat is accepted. The bits therefore keep moving across word boundaries from beat to beat and from packet to packet.

A 32-bit count of completed packets is available for a status register. A synchronous, active-high clear input, meant to be driven from a control register bit, restarts the sequencer, the pattern and the count in the same way that reset does.

Data width is a build parameter, with 8, 64 and 256 bits supported. Packet length in bytes, gap length in cycles and the seed are also build parameters.

Top module: `stream_pattern_gen`

## Requirements
- R1: In the cycle after an edge at which `rst_n` is low or `clear` is high, `m_tvalid` is 0 and `pkt_count` is 0. The next packet then starts again from the first beat with the initial pattern. `clear` takes precedence over every other input.
- R2: Each packet has BEATS = ceil(PKT_BYTES / (DATA_W/8)) beats. `m_tlast` is high only on the final beat.
- R3: `m_tkeep` bit i covers byte lane `m_tdata[8i+7:8i]`. It is all ones on every beat except the final one. On the final beat only the lowest PKT_BYTES - (BEATS-1)*(DATA_W/8) bits are set.
- R4: Let n count the beats accepted since reset or clear, starting from 0. The data offered on beat n is P rotated left by (n mod DATA_W) bits, where bit i of P equals SEED[i mod 32]. Lanes whose keep bit is 0 carry zero. The rotation continues across packet boundaries.
- R5: A beat that is offered and not accepted (`m_tvalid` high, `m_tready` low) is offered again, unchanged, in the next cycle, with the same data, keep and last. Neither the pattern nor the beat position advances.
- R6: After the final beat of a packet is accepted, `m_tvalid` stays low for exactly GAP_CYCLES cycles and then rises, provided `enable` is held high. With GAP_CYCLES = 0, packets follow each other with no idle cycle.
- R7: A packet begins only when `enable` is high. Lowering `enable` during a packet does not cut the packet short. If the block is idle and `enable` is sampled high, `m_tvalid` is high in the next cycle. While `enable` stays low after a packet ends, `m_tvalid` stays low.
- R8: `pkt_count` increases by exactly one at each accepted final beat, is otherwise unchanged, and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous restart, active high |
| enable | input | 1 | Allows a new packet to start |
| m_tready | input | 1 | Downstream ready |
| m_tvalid | output | 1 | Beat offered |
| m_tdata | output | DATA_W | Pattern data |
| m_tkeep | output | DATA_W/8 | Byte-lane valid mask |
| m_tlast | output | 1 | Final beat of a packet |
| pkt_count | output | 32 | Completed packet count |

## Verification
The assertions assume that `rst_n` is held low for several cycles from time zero, so that every register has a known value before any `$past` term is evaluated. They also assume that `clear` and `enable` change only between clock edges. The stall property depends on `m_tready` being free to drop while a beat is waiting. The bench therefore sweeps `m_tready` through all-high, alternating, burst-low and pseudo-random sequences. It drives every input at the falling edge, lowers `enable` both in the middle of a packet and during the gap, and applies `clear` in the middle of a packet. The gap length is checked only over gaps during which `enable` stayed high.

// File: rtl/spg_pkg.sv
// Shared types for the streaming test pattern generator.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package spg_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SEND = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/spg_beat_seq.sv
// Beat sequencer: tracks the beat position within a packet and the idle
// gap that follows each packet. It decides when a beat is offered.
// Assumes BEATS >= 1. GAP may be 0, which gives back-to-back packets.
module spg_beat_seq #(
    parameter int BEATS = 3,
    parameter int GAP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic ready,
    output logic valid,
    output logic last,
    output logic accept,
    output logic pkt_done
);
    import spg_pkg::*;

    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int GAP_W  = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'((GAP > 0) ? GAP - 1 : 0);

    seq_state_e        state;
    logic [BEAT_W-1:0] beat;
    logic [GAP_W-1:0]  gap_left;

    // Decode of the offered beat from the state and beat position
    always_comb begin
        valid    = (state == SEQ_SEND);
        last     = valid && (beat == LAST_BEAT);
        accept   = valid && ready;
        pkt_done = accept && last;
    end

    // State, beat position and gap countdown
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state    <= SEQ_IDLE;
            beat     <= '0;
            gap_left <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (enable) state <= SEQ_SEND;
                end
                SEQ_SEND: begin
                    if (ready) begin
                        if (beat == LAST_BEAT) begin
                            beat <= '0;
                            if (GAP == 0) begin
                                state <= enable ? SEQ_SEND : SEQ_IDLE;
                            end else begin
                                state    <= SEQ_GAP;
                                gap_left <= GAP_LOAD;
                            end
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                SEQ_GAP: begin
                    if (gap_left == '0) begin
                        state <= enable ? SEQ_SEND : SEQ_IDLE;
                    end else begin
                        gap_left <= gap_left - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R5
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !clear |=> valid && $stable(beat));

    // R1
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !valid && beat == '0);

    generate
        if (GAP > 0) begin : g_gap_chk
            // R6
            gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pkt_done && !clear |=> !valid);
        end
    endgenerate
endmodule

// File: rtl/spg_pattern.sv
// Pattern source: holds a DATA_W-bit word that is seeded from a 32-bit
// constant repeated across the word and rotated left by one bit for each
// accepted beat. Assumes DATA_W >= 8.
module spg_pattern #(
    parameter int          DATA_W = 64,
    parameter logic [31:0] SEED   = 32'h9E37_79B1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] seed_word;

    // Repeat the 32-bit seed across the full data width
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_seed
            assign seed_word[i] = SEED[i % 32];
        end
    endgenerate

    // Rotate the pattern word on each accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= seed_word;
        end else if (advance) begin
            word <= {word[DATA_W-2:0], word[DATA_W-1]};
        end
    end

    // R5
    pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance && !clear |=> $stable(word));

    // R4
    pattern_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !clear |=> word == {$past(word[DATA_W-2:0]), $past(word[DATA_W-1])});
endmodule

// File: rtl/spg_pkt_count.sv
// Packet counter: a 32-bit count of completed packets that wraps on
// overflow. Assumes that inc is a single-cycle pulse for each final beat
// accepted.
module spg_pkt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count completed packets, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clear |=> count == $past(count) + 1'b1);

    // R8
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !clear |=> $stable(count));

    // R1
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);
endmodule

// File: rtl/stream_pattern_gen.sv
// Streaming test pattern generator top. It sends fixed-length packets of
// rotating pattern data, with an idle gap between packets, and counts the
// packets it completes. Assumes DATA_W is one of 8, 64 or 256 and that
// PKT_BYTES >= 1.
module stream_pattern_gen #(
    parameter int          DATA_W     = 64,
    parameter int          PKT_BYTES  = 20,
    parameter int          GAP_CYCLES = 3,
    parameter logic [31:0] SEED       = 32'h9E37_79B1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                enable,
    input  logic                m_tready,
    output logic                m_tvalid,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic                m_tlast,
    output logic [31:0]         pkt_count
);
    localparam int LANES      = DATA_W / 8;
    localparam int BEATS      = (PKT_BYTES + LANES - 1) / LANES;
    localparam int LAST_LANES = PKT_BYTES - (BEATS - 1) * LANES;

    logic              accept;
    logic              pkt_done;
    logic [DATA_W-1:0] pat_word;
    logic [LANES-1:0]  last_keep;

    spg_beat_seq #(.BEATS(BEATS), .GAP(GAP_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
        .ready(m_tready), .valid(m_tvalid), .last(m_tlast),
        .accept(accept), .pkt_done(pkt_done)
    );

    spg_pattern #(.DATA_W(DATA_W), .SEED(SEED)) u_pat (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .advance(accept), .word(pat_word)
    );

    spg_pkt_count #(.CNT_W(32)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .inc(pkt_done), .count(pkt_count)
    );

    // Keep mask of the final beat and zeroing of unused byte lanes
    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign last_keep[b]      = (b < LAST_LANES);
            assign m_tdata[8*b +: 8] = m_tkeep[b] ? pat_word[8*b +: 8] : 8'h00;
        end
    endgenerate

    // Choose the keep mask for the beat on offer
    always_comb begin
        m_tkeep = m_tlast ? last_keep : '1;
    end

    // R5
    beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready && !clear |=>
        m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

    // R3
    keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tlast |-> &m_tkeep);

    // R3
    keep_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tlast |-> $countones(m_tkeep) == LAST_LANES);
endmodule

// File: tb/stream_pattern_gen_test.sv
`timescale 1ns/1ps
module stream_pattern_gen_test;
    localparam int          DW    = 64;
    localparam int          PB    = 20;
    localparam int          GAP   = 3;
    localparam logic [31:0] SEED  = 32'h9E37_79B1;
    localparam int          LN    = DW / 8;
    localparam int          BEATS = (PB + LN - 1) / LN;
    localparam int          LASTB = PB - (BEATS - 1) * LN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          enable = 1'b0;
    logic          m_tready = 1'b0;
    logic          m_tvalid;
    logic [DW-1:0] m_tdata;
    logic [LN-1:0] m_tkeep;
    logic          m_tlast;
    logic [31:0]   pkt_count;

    stream_pattern_gen #(.DATA_W(DW), .PKT_BYTES(PB), .GAP_CYCLES(GAP), .SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
        .m_tready(m_tready), .m_tvalid(m_tvalid), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tlast(m_tlast), .pkt_count(pkt_count)
    );

    always #4 clk = ~clk;

    int            vectors = 0;
    int            errors = 0;
    bit            done = 1'b0;
    logic [DW-1:0] exp_pat;
    int            exp_beat;
    logic [31:0]   exp_cnt;
    int            lowcnt;
    bit            after_last;
    bit            en_held;
    bit            prev_stall;
    logic [DW-1:0] prev_data;
    logic [LN-1:0] prev_keep;
    logic          prev_last;
    bit            quiet_expected = 1'b0;
    bit            want_valid = 1'b0;
    logic [15:0]   lfsr = 16'hACE1;

    // Record one check and report it when it fails
    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Seed word: bit i equals SEED[i mod 32]
    function automatic logic [DW-1:0] seed_word();
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = SEED[i % 32];
        return w;
    endfunction

    // Zero the lanes whose keep bit is clear
    function automatic logic [DW-1:0] masked(input logic [DW-1:0] p, input logic [LN-1:0] k);
        logic [DW-1:0] m = '0;
        for (int b = 0; b < LN; b++) if (k[b]) m[8*b +: 8] = p[8*b +: 8];
        return m;
    endfunction

    // Return the model to its state after reset or clear
    task automatic model_reset();
        exp_pat    = seed_word();
        exp_beat   = 0;
        exp_cnt    = '0;
        lowcnt     = 0;
        after_last = 1'b0;
        en_held    = 1'b1;
        prev_stall = 1'b0;
    endtask

    // Step the pseudo-random source for ready and enable
    task automatic lfsr_step();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // One cycle: check outputs at the falling edge, drive inputs, update the model
    task automatic step(input bit rdy, input bit en);
        logic [LN-1:0] ek;
        bit acc, lacc;
        @(negedge clk);
        check(pkt_count == exp_cnt, "R8", "pkt_count", pkt_count, exp_cnt);
        if (quiet_expected) check(!m_tvalid, "R7", "tvalid while disabled", m_tvalid, 0);
        if (want_valid) begin
            check(m_tvalid, "R7", "tvalid after enable", m_tvalid, 1);
            want_valid = 1'b0;
        end
        if (prev_stall) begin
            check(m_tvalid, "R5", "tvalid held", m_tvalid, 1);
            check(m_tdata == prev_data && m_tkeep == prev_keep && m_tlast == prev_last,
                  "R5", "held beat", m_tdata, prev_data);
        end
        if (m_tvalid) begin
            ek = (exp_beat == BEATS - 1) ? LN'((1 << LASTB) - 1) : '1;
            check(m_tlast == (exp_beat == BEATS - 1), "R2", "tlast", m_tlast, exp_beat == BEATS - 1);
            check(m_tkeep == ek, "R3", "tkeep", m_tkeep, ek);
            check(m_tdata == masked(exp_pat, ek), "R4", "tdata", m_tdata, masked(exp_pat, ek));
            if (after_last) begin
                if (en_held) check(lowcnt == GAP, "R6", "gap length", lowcnt, GAP);
                after_last = 1'b0;
            end
        end else if (after_last) begin
            lowcnt++;
        end
        m_tready   = rdy;
        enable     = en;
        acc        = m_tvalid && rdy;
        lacc       = acc && m_tlast;
        prev_stall = m_tvalid && !rdy;
        prev_data  = m_tdata;
        prev_keep  = m_tkeep;
        prev_last  = m_tlast;
        if (after_last && !en) en_held = 1'b0;
        @(posedge clk);
        if (acc) begin
            exp_pat = {exp_pat[DW-2:0], exp_pat[DW-1]};
            exp_beat++;
            if (lacc) begin
                exp_beat   = 0;
                exp_cnt    = exp_cnt + 1;
                after_last = 1'b1;
                lowcnt     = 0;
                en_held    = 1'b1;
            end
        end
    endtask

    // Print the summary line once
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        // R1: state while reset is held
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!m_tvalid, "R1", "tvalid in reset", m_tvalid, 0);
        check(pkt_count == 0, "R1", "count in reset", pkt_count, 0);
        rst_n = 1'b1;

        // R7: no packet while enable is low, then start on the next cycle
        quiet_expected = 1'b1;
        repeat (6) step(1'b1, 1'b0);
        quiet_expected = 1'b0;
        step(1'b1, 1'b1);
        want_valid = 1'b1;

        // R2 R3 R4 R6: full-rate stream
        for (int i = 0; i < 60; i++) step(1'b1, 1'b1);
        // R5: alternating ready
        for (int i = 0; i < 60; i++) step(i[0], 1'b1);
        // R5: long ready-low bursts
        for (int i = 0; i < 80; i++) step((i % 7) < 2, 1'b1);
        // Pseudo-random ready
        for (int i = 0; i < 300; i++) begin
            lfsr_step();
            step(lfsr[0], 1'b1);
        end
        // R7: enable toggling, including in the middle of a packet
        for (int i = 0; i < 200; i++) begin
            lfsr_step();
            step(lfsr[0] | lfsr[4], lfsr[3] | lfsr[7]);
        end

        // R7: lower enable mid-stream; the current packet must still finish
        for (int i = 0; i < 2 * BEATS + 2 && !after_last; i++) step(1'b1, 1'b0);
        check(after_last, "R7", "packet completed with enable low", after_last, 1);
        for (int i = 0; i < GAP + 1; i++) step(1'b1, 1'b0);
        quiet_expected = 1'b1;
        repeat (8) step(1'b1, 1'b0);
        quiet_expected = 1'b0;
        step(1'b1, 1'b1);
        want_valid = 1'b1;

        // R1: clear in the middle of a packet
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        @(negedge clk);
        clear = 1'b1;
        enable = 1'b1;
        m_tready = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        check(!m_tvalid, "R1", "tvalid after clear", m_tvalid, 0);
        check(pkt_count == 0, "R1", "count after clear", pkt_count, 0);
        clear = 1'b0;
        @(posedge clk);
        // After clear the first beat must carry the initial pattern (R1, R4)
        for (int i = 0; i < 200; i++) begin
            lfsr_step();
            step(lfsr[1] | lfsr[2], 1'b1);
        end
        finish_run();
    end
endmodule